// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block is the address-translation core of a game cartridge. It sits between three parties: an 8-bit CPU bus with a 16-bit address, a pattern bus with a 14-bit address, and the cartridge memories. On the CPU side it decodes an 8 KiB battery-backed work RAM and one switchable 32 KiB program ROM window. On the pattern side it splits the lower 8 KiB into two 4 KiB windows. Each window has its own bank register. Nametable accesses go to the 2 KiB console video RAM with fixed horizontal mirroring.

Software selects banks by writing the last three bytes of the work RAM range. The byte at 0x7FFD picks the program bank from data bit 0. The byte at 0x7FFE holds the 4-bit bank for the lower pattern half, and 0x7FFF holds the bank for the upper half. These writes also land in work RAM. All translated addresses and chip selects are combinational from the bus address and the current registers. The memories are synchronous, so read data is muxed by a select that is registered together with the request.

Top module: `cart_bank_mapper`

## Requirements
- R1: While rst_ni is low, and after it rises, the program bank and both pattern banks are 0. CPU 0x8000 maps to ROM address 0 and pattern 0x1000 maps to pattern address 0. Reset does not touch work RAM contents.
- R2: CPU addresses 0x6000–0x7FFF assert wram_cs_o with wram_addr_o equal to address bits 12:0. wram_we_o follows cpu_we_i. A write is stored and read back at that index.
- R3: CPU addresses 0x8000–0xFFFF assert prg_cs_o with prg_addr_o = bank*0x8000 + address bits 14:0.
- R4: A CPU write to 0x7FFD loads the program bank from data bit 0 only, and other data bits have no effect. The new bank applies from the cycle after the write.
- R5: A CPU write to 0x7FFE loads data bits 3:0 as the bank for pattern 0x0000–0x0FFF. A write to 0x7FFF does the same for 0x1000–0x1FFF. In both cases chr_addr_o = bank*0x1000 + address bits 11:0.
- R6: Writes to 0x7FFD, 0x7FFE and 0x7FFF are also stored in work RAM and read back unchanged, including all 8 data bits.
- R7: Bank numbers are reduced modulo the number of banks present (PRG_BANKS, CHR_BANKS). With CHR_BANKS=12, bank 13 maps to bank 1 and chr_addr_o always stays below CHR_BANKS*0x1000.
- R8: Pattern addresses 0x2000–0x3EFF assert nt_cs_o with nt_addr_o = {address bit 11, address bits 9:0}. Bit 10 is ignored, and 0x3000–0x3EFF alias 0x2000–0x2EFF. Addresses 0x3F00–0x3FFF select nothing and read 0.
- R9: Pattern addresses 0x0000–0x1FFF assert chr_cs_o. A pattern write sets chr_we_o and stores the data at the banked address.
- R10: CPU addresses 0x0000–0x5FFF assert no chip select and read 0. A write there changes neither memory nor any bank register.
- R11: cpu_rdata_o and ppu_rdata_o present the data for the address applied one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_rdata_o | output | 8 | CPU read data, one cycle after the address |
| wram_cs_o | output | 1 | Work RAM select |
| wram_we_o | output | 1 | Work RAM write enable |
| wram_addr_o | output | 13 | Work RAM address |
| wram_wdata_o | output | 8 | Work RAM write data |
| wram_rdata_i | input | 8 | Work RAM read data |
| prg_cs_o | output | 1 | Program ROM select |
| prg_addr_o | output | PRG_AW | Program ROM address |
| prg_rdata_i | input | 8 | Program ROM read data |
| ppu_addr_i | input | 14 | Pattern bus address |
| ppu_wdata_i | input | 8 | Pattern bus write data |
| ppu_we_i | input | 1 | Pattern bus write strobe |
| ppu_rdata_o | output | 8 | Pattern bus read data, one cycle after the address |
| chr_cs_o | output | 1 | Pattern memory select |
| chr_we_o | output | 1 | Pattern memory write enable |
| chr_addr_o | output | CHR_AW | Pattern memory address |
| chr_wdata_o | output | 8 | Pattern memory write data |
| chr_rdata_i | input | 8 | Pattern memory read data |
| nt_cs_o | output | 1 | Nametable RAM select |
| nt_we_o | output | 1 | Nametable RAM write enable |
| nt_addr_o | output | 11 | Nametable RAM address |
| nt_wdata_o | output | 8 | Nametable write data |
| nt_rdata_i | input | 8 | Nametable RAM read data |

## Verification
Selects and translated addresses are combinational. The bench therefore samples them in the same cycle the address is driven, a quarter period after the falling edge. Read data comes through a synchronous memory and the registered select, so it is due exactly one edge later. The reference model computes that value at the edge and compares it during the following cycle. Bank register writes take effect at the write edge, so the model updates its registers after it has computed that edge's read data and translated addresses. The first access after a register write is therefore checked against the new bank.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  typedef enum logic [1:0] {
    CPU_NONE = 2'd0,
    CPU_WRAM = 2'd1,
    CPU_PRG  = 2'd2
  } cpu_sel_e;

  typedef enum logic [1:0] {
    PPU_NONE = 2'd0,
    PPU_CHR  = 2'd1,
    PPU_NT   = 2'd2
  } ppu_sel_e;

  localparam logic [15:0] REG_PRG_ADDR = 16'h7FFD;
  localparam logic [15:0] REG_CHR_BASE = 16'h7FFE;
  localparam int          NUM_CHR_REGS = 2;
  localparam int          CHR_REG_W    = 4;
  localparam int          WRAM_AW      = 13;
  localparam int          NT_AW        = 11;

  function automatic cpu_sel_e cpu_region(input logic [15:0] a);
    if (a[15])                 return CPU_PRG;
    else if (a[14:13] == 2'b11) return CPU_WRAM;
    else                       return CPU_NONE;
  endfunction

  function automatic ppu_sel_e ppu_region(input logic [13:0] a);
    if (!a[13])                 return PPU_CHR;
    else if (a[12:8] == 5'h1F)  return PPU_NONE;
    else                        return PPU_NT;
  endfunction

endpackage

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs
  import mapper_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [15:0]                        addr_i,
  input  logic [CHR_REG_W-1:0]               wdata_i,
  output logic                               prg_bank_o,
  output logic [NUM_CHR_REGS-1:0][CHR_REG_W-1:0] chr_bank_o
);

  logic prg_q;
  logic [NUM_CHR_REGS-1:0][CHR_REG_W-1:0] chr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prg_q <= 1'b0;
    end else if (we_i && addr_i == REG_PRG_ADDR) begin
      prg_q <= wdata_i[0];
    end
  end

  for (genvar g = 0; g < NUM_CHR_REGS; g++) begin : g_chr_reg
    localparam logic [15:0] RegAddr = REG_CHR_BASE + 16'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chr_q[g] <= '0;
      end else if (we_i && addr_i == RegAddr) begin
        chr_q[g] <= wdata_i;
      end
    end
  end

  assign prg_bank_o = prg_q;
  assign chr_bank_o = chr_q;

endmodule

// File: rtl/mapper_cpu_side.sv
module mapper_cpu_side
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 2,
  parameter int PRG_AW    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        cpu_addr_i,
  input  logic [7:0]         cpu_wdata_i,
  input  logic               cpu_we_i,
  output logic [7:0]         cpu_rdata_o,
  input  logic               prg_bank_i,
  output logic               wram_cs_o,
  output logic               wram_we_o,
  output logic [WRAM_AW-1:0] wram_addr_o,
  output logic [7:0]         wram_wdata_o,
  input  logic [7:0]         wram_rdata_i,
  output logic               prg_cs_o,
  output logic [PRG_AW-1:0]  prg_addr_o,
  input  logic [7:0]         prg_rdata_i
);

  localparam int PRG_BW = PRG_AW - 15;

  cpu_sel_e sel_d, sel_q;
  logic [PRG_BW-1:0] bank_mod;

  assign sel_d    = cpu_region(cpu_addr_i);
  // wrap onto banks actually present
  assign bank_mod = PRG_BW'(32'(prg_bank_i) % PRG_BANKS);

  assign wram_cs_o    = (sel_d == CPU_WRAM);
  assign wram_we_o    = wram_cs_o && cpu_we_i;
  assign wram_addr_o  = cpu_addr_i[WRAM_AW-1:0];
  assign wram_wdata_o = cpu_wdata_i;

  assign prg_cs_o   = (sel_d == CPU_PRG);
  assign prg_addr_o = {bank_mod, cpu_addr_i[14:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= CPU_NONE;
    else         sel_q <= sel_d;
  end

  always_comb begin
    unique case (sel_q)
      CPU_WRAM: cpu_rdata_o = wram_rdata_i;
      CPU_PRG:  cpu_rdata_o = prg_rdata_i;
      default:  cpu_rdata_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/mapper_ppu_side.sv
module mapper_ppu_side
  import mapper_pkg::*;
#(
  parameter int CHR_BANKS = 12,
  parameter int CHR_AW    = 16
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [13:0]                            ppu_addr_i,
  input  logic [7:0]                             ppu_wdata_i,
  input  logic                                   ppu_we_i,
  output logic [7:0]                             ppu_rdata_o,
  input  logic [NUM_CHR_REGS-1:0][CHR_REG_W-1:0] chr_bank_i,
  output logic                                   chr_cs_o,
  output logic                                   chr_we_o,
  output logic [CHR_AW-1:0]                      chr_addr_o,
  output logic [7:0]                             chr_wdata_o,
  input  logic [7:0]                             chr_rdata_i,
  output logic                                   nt_cs_o,
  output logic                                   nt_we_o,
  output logic [NT_AW-1:0]                       nt_addr_o,
  output logic [7:0]                             nt_wdata_o,
  input  logic [7:0]                             nt_rdata_i
);

  localparam int CHR_BW = CHR_AW - 12;

  ppu_sel_e sel_d, sel_q;
  logic [CHR_REG_W-1:0] bank_raw;
  logic [CHR_BW-1:0]    bank_mod;

  assign sel_d    = ppu_region(ppu_addr_i);
  assign bank_raw = chr_bank_i[ppu_addr_i[12]];
  assign bank_mod = CHR_BW'(32'(bank_raw) % CHR_BANKS);

  assign chr_cs_o    = (sel_d == PPU_CHR);
  assign chr_we_o    = chr_cs_o && ppu_we_i;
  assign chr_addr_o  = {bank_mod, ppu_addr_i[11:0]};
  assign chr_wdata_o = ppu_wdata_i;

  // fixed horizontal arrangement: bit 11 picks the page, bit 10 dropped
  assign nt_cs_o    = (sel_d == PPU_NT);
  assign nt_we_o    = nt_cs_o && ppu_we_i;
  assign nt_addr_o  = {ppu_addr_i[11], ppu_addr_i[9:0]};
  assign nt_wdata_o = ppu_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= PPU_NONE;
    else         sel_q <= sel_d;
  end

  always_comb begin
    unique case (sel_q)
      PPU_CHR: ppu_rdata_o = chr_rdata_i;
      PPU_NT:  ppu_rdata_o = nt_rdata_i;
      default: ppu_rdata_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 2,
  parameter int CHR_BANKS = 12,
  parameter int PRG_AW    = 15 + ((PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1),
  parameter int CHR_AW    = 12 + ((CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  input  logic              cpu_we_i,
  output logic [7:0]        cpu_rdata_o,
  output logic              wram_cs_o,
  output logic              wram_we_o,
  output logic [12:0]       wram_addr_o,
  output logic [7:0]        wram_wdata_o,
  input  logic [7:0]        wram_rdata_i,
  output logic              prg_cs_o,
  output logic [PRG_AW-1:0] prg_addr_o,
  input  logic [7:0]        prg_rdata_i,
  input  logic [13:0]       ppu_addr_i,
  input  logic [7:0]        ppu_wdata_i,
  input  logic              ppu_we_i,
  output logic [7:0]        ppu_rdata_o,
  output logic              chr_cs_o,
  output logic              chr_we_o,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic [7:0]        chr_wdata_o,
  input  logic [7:0]        chr_rdata_i,
  output logic              nt_cs_o,
  output logic              nt_we_o,
  output logic [10:0]       nt_addr_o,
  output logic [7:0]        nt_wdata_o,
  input  logic [7:0]        nt_rdata_i
);

  logic prg_bank;
  logic [NUM_CHR_REGS-1:0][CHR_REG_W-1:0] chr_bank;

  mapper_bank_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cpu_we_i),
    .addr_i     (cpu_addr_i),
    .wdata_i    (cpu_wdata_i[CHR_REG_W-1:0]),
    .prg_bank_o (prg_bank),
    .chr_bank_o (chr_bank)
  );

  mapper_cpu_side #(
    .PRG_BANKS (PRG_BANKS),
    .PRG_AW    (PRG_AW)
  ) i_cpu (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_rdata_o  (cpu_rdata_o),
    .prg_bank_i   (prg_bank),
    .wram_cs_o    (wram_cs_o),
    .wram_we_o    (wram_we_o),
    .wram_addr_o  (wram_addr_o),
    .wram_wdata_o (wram_wdata_o),
    .wram_rdata_i (wram_rdata_i),
    .prg_cs_o     (prg_cs_o),
    .prg_addr_o   (prg_addr_o),
    .prg_rdata_i  (prg_rdata_i)
  );

  mapper_ppu_side #(
    .CHR_BANKS (CHR_BANKS),
    .CHR_AW    (CHR_AW)
  ) i_ppu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ppu_addr_i  (ppu_addr_i),
    .ppu_wdata_i (ppu_wdata_i),
    .ppu_we_i    (ppu_we_i),
    .ppu_rdata_o (ppu_rdata_o),
    .chr_bank_i  (chr_bank),
    .chr_cs_o    (chr_cs_o),
    .chr_we_o    (chr_we_o),
    .chr_addr_o  (chr_addr_o),
    .chr_wdata_o (chr_wdata_o),
    .chr_rdata_i (chr_rdata_i),
    .nt_cs_o     (nt_cs_o),
    .nt_we_o     (nt_we_o),
    .nt_addr_o   (nt_addr_o),
    .nt_wdata_o  (nt_wdata_o),
    .nt_rdata_i  (nt_rdata_i)
  );

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
  parameter int CHR_BANKS = 12,
  parameter int CHR_AW    = 16,
  parameter int PRG_AW    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       cpu_addr_i,
  input logic              cpu_we_i,
  input logic [7:0]        cpu_rdata_o,
  input logic              wram_cs_o,
  input logic              wram_we_o,
  input logic              prg_cs_o,
  input logic [PRG_AW-1:0] prg_addr_o,
  input logic [13:0]       ppu_addr_i,
  input logic [7:0]        ppu_rdata_o,
  input logic              chr_cs_o,
  input logic [CHR_AW-1:0] chr_addr_o,
  input logic              nt_cs_o
);

  AST_CPU_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wram_cs_o, prg_cs_o})); // R2

  AST_WRAM_WE_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wram_we_o |-> (wram_cs_o && cpu_we_i)); // R6

  AST_PRG_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cpu_we_i) && $stable(cpu_addr_i)) |-> $stable(prg_addr_o)); // R4

  AST_CHR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_cs_o |-> (32'(chr_addr_o) < CHR_BANKS * 4096)); // R7

  AST_PPU_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chr_cs_o, nt_cs_o})); // R8

  AST_PPU_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ppu_addr_i) >= 14'h3F00) |-> (ppu_rdata_o == 8'h00)); // R8

  AST_CPU_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cpu_addr_i) < 16'h6000) |-> (cpu_rdata_o == 8'h00)); // R10

endmodule

bind cart_bank_mapper mapper_checker #(
  .CHR_BANKS (CHR_BANKS),
  .CHR_AW    (CHR_AW),
  .PRG_AW    (PRG_AW)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_rdata_o (cpu_rdata_o),
  .wram_cs_o   (wram_cs_o),
  .wram_we_o   (wram_we_o),
  .prg_cs_o    (prg_cs_o),
  .prg_addr_o  (prg_addr_o),
  .ppu_addr_i  (ppu_addr_i),
  .ppu_rdata_o (ppu_rdata_o),
  .chr_cs_o    (chr_cs_o),
  .chr_addr_o  (chr_addr_o),
  .nt_cs_o     (nt_cs_o)
);

// File: tb/test_cart_bank_mapper.sv
module test_cart_bank_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int PRG_BANKS  = 2;
  localparam int CHR_BANKS  = 12;
  localparam int PRG_AW     = 16;
  localparam int CHR_AW     = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [13:0] ppu_addr = 14'h3F00;
  logic [7:0]  ppu_wdata = '0;
  logic        ppu_we = 1'b0;

  logic [7:0]  cpu_rdata, ppu_rdata;
  logic        wram_cs, wram_we, prg_cs, chr_cs, chr_we, nt_cs, nt_we;
  logic [12:0] wram_addr;
  logic [7:0]  wram_wdata, chr_wdata, nt_wdata;
  logic [PRG_AW-1:0] prg_addr;
  logic [CHR_AW-1:0] chr_addr;
  logic [10:0] nt_addr;
  logic [7:0]  wram_rd = '0, prg_rd = '0, chr_rd = '0, nt_rd = '0;

  cart_bank_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) i_cart_bank_mapper (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_we_i(cpu_we), .cpu_rdata_o(cpu_rdata),
    .wram_cs_o(wram_cs), .wram_we_o(wram_we), .wram_addr_o(wram_addr),
    .wram_wdata_o(wram_wdata), .wram_rdata_i(wram_rd),
    .prg_cs_o(prg_cs), .prg_addr_o(prg_addr), .prg_rdata_i(prg_rd),
    .ppu_addr_i(ppu_addr), .ppu_wdata_i(ppu_wdata), .ppu_we_i(ppu_we), .ppu_rdata_o(ppu_rdata),
    .chr_cs_o(chr_cs), .chr_we_o(chr_we), .chr_addr_o(chr_addr),
    .chr_wdata_o(chr_wdata), .chr_rdata_i(chr_rd),
    .nt_cs_o(nt_cs), .nt_we_o(nt_we), .nt_addr_o(nt_addr),
    .nt_wdata_o(nt_wdata), .nt_rdata_i(nt_rd)
  );

  function automatic logic [7:0] rom_byte(int a);
    return 8'((a * 29) ^ (a >> 7));
  endfunction
  function automatic logic [7:0] chr_init(int a);
    return 8'((a * 13) ^ (a >> 5) ^ 8'h5A);
  endfunction

  // cartridge memory models driven by the design
  logic [7:0] wram_m [int];
  logic [7:0] chr_m  [int];
  logic [7:0] nt_m   [int];
  always @(posedge clk) begin
    if (wram_cs) begin
      wram_rd <= wram_m.exists(int'(wram_addr)) ? wram_m[int'(wram_addr)] : 8'h00;
      if (wram_we) wram_m[int'(wram_addr)] = wram_wdata;
    end
    if (prg_cs) prg_rd <= rom_byte(int'(prg_addr));
    if (chr_cs) begin
      chr_rd <= chr_m.exists(int'(chr_addr)) ? chr_m[int'(chr_addr)] : chr_init(int'(chr_addr));
      if (chr_we) chr_m[int'(chr_addr)] = chr_wdata;
    end
    if (nt_cs) begin
      nt_rd <= nt_m.exists(int'(nt_addr)) ? nt_m[int'(nt_addr)] : 8'h00;
      if (nt_we) nt_m[int'(nt_addr)] = nt_wdata;
    end
  end

  // reference model state
  int m_prg = 0;
  int m_chr [2] = '{0, 0};
  logic [7:0] s_wram [int];
  logic [7:0] s_chr  [int];
  logic [7:0] s_nt   [int];
  int exp_cpu_rd = 0, exp_ppu_rd = 0;
  string cpu_rd_tag = "R11 R10", ppu_rd_tag = "R11 R8";

  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_prg(int a);
    return (m_prg % PRG_BANKS) * 32'h8000 + (a & 32'h7FFF);
  endfunction
  function automatic int exp_chr(int a);
    return (m_chr[(a >> 12) & 1] % CHR_BANKS) * 32'h1000 + (a & 32'hFFF);
  endfunction
  function automatic int exp_nt(int a);
    return ((a >> 11) & 1) * 1024 + (a & 32'h3FF);
  endfunction

  task automatic step(input int ca, input bit cw, input int cd,
                      input int pa, input bit pw, input int pd, input string tag = "R3");
    bit in_w, in_p, in_c, in_n;
    @(negedge clk);
    cpu_addr = 16'(ca); cpu_we = cw; cpu_wdata = 8'(cd);
    ppu_addr = 14'(pa); ppu_we = pw; ppu_wdata = 8'(pd);
    #(CLK_PERIOD/4);
    chk(cpu_rd_tag, "cpu_rdata", int'(cpu_rdata), exp_cpu_rd);
    chk(ppu_rd_tag, "ppu_rdata", int'(ppu_rdata), exp_ppu_rd);
    in_w = (ca >= 32'h6000 && ca <= 32'h7FFF);
    in_p = (ca >= 32'h8000);
    in_c = (pa < 32'h2000);
    in_n = (pa >= 32'h2000 && pa < 32'h3F00);
    chk("R2", "wram_cs", int'(wram_cs), int'(in_w));
    chk("R3", "prg_cs", int'(prg_cs), int'(in_p));
    chk("R9", "chr_cs", int'(chr_cs), int'(in_c));
    chk("R8", "nt_cs", int'(nt_cs), int'(in_n));
    if (in_w) begin
      chk("R2", "wram_addr", int'(wram_addr), ca & 32'h1FFF);
      chk("R2", "wram_we", int'(wram_we), int'(cw));
    end
    if (in_p) chk(tag, "prg_addr", int'(prg_addr), exp_prg(ca));
    if (in_c) begin
      chk(tag, "chr_addr", int'(chr_addr), exp_chr(pa));
      chk("R9", "chr_we", int'(chr_we), int'(pw));
    end
    if (in_n) chk("R8", "nt_addr", int'(nt_addr), exp_nt(pa));
    @(posedge clk);
    // results of this edge, then state updates
    if (in_w) begin
      exp_cpu_rd = s_wram.exists(ca & 32'h1FFF) ? int'(s_wram[ca & 32'h1FFF]) : 0;
      cpu_rd_tag = (ca >= 32'h7FFD) ? "R11 R6" : "R11 R2";
      if (cw) s_wram[ca & 32'h1FFF] = 8'(cd);
    end else if (in_p) begin
      exp_cpu_rd = int'(rom_byte(exp_prg(ca)));
      cpu_rd_tag = "R11 R3";
    end else begin
      exp_cpu_rd = 0;
      cpu_rd_tag = "R11 R10";
    end
    if (in_c) begin
      int k = exp_chr(pa);
      exp_ppu_rd = s_chr.exists(k) ? int'(s_chr[k]) : int'(chr_init(k));
      ppu_rd_tag = "R11 R9";
      if (pw) s_chr[k] = 8'(pd);
    end else if (in_n) begin
      int k = exp_nt(pa);
      exp_ppu_rd = s_nt.exists(k) ? int'(s_nt[k]) : 0;
      ppu_rd_tag = "R11 R8";
      if (pw) s_nt[k] = 8'(pd);
    end else begin
      exp_ppu_rd = 0;
      ppu_rd_tag = "R11 R8";
    end
    if (cw && ca == 32'h7FFD) m_prg = cd & 1;
    if (cw && ca == 32'h7FFE) m_chr[0] = cd & 15;
    if (cw && ca == 32'h7FFF) m_chr[1] = cd & 15;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset cpu_rdata", int'(cpu_rdata), 0);
    chk("R1", "reset ppu_rdata", int'(ppu_rdata), 0);
    @(negedge clk); rst_ni = 1'b1;
    // R1: banks start at 0
    step(32'h8000, 0, 0, 32'h1000, 0, 0, "R1");
    step(32'hFFFF, 0, 0, 32'h0FFF, 0, 0, "R1");
    // R10: unmapped CPU range, writes have no effect
    step(32'h0000, 0, 0, 32'h3F00, 0, 0);
    step(32'h5FFF, 1, 32'hFF, 32'h3FFF, 0, 0);
    step(32'h4020, 1, 32'h01, 32'h3F10, 0, 0);
    step(32'h8000, 0, 0, 32'h1234, 0, 0, "R10");
    // R2: work RAM write and readback
    step(32'h6000, 1, 32'hA5, 32'h3F00, 0, 0);
    step(32'h7123, 1, 32'h3C, 32'h3F00, 0, 0);
    step(32'h6000, 0, 0, 32'h3F00, 0, 0);
    step(32'h7123, 0, 0, 32'h3F00, 0, 0);
    // R4: only bit 0 of the program bank write counts
    step(32'h7FFD, 1, 32'hFE, 32'h3F00, 0, 0);
    step(32'h8000, 0, 0, 32'h3F00, 0, 0, "R4");
    step(32'h7FFD, 1, 32'h03, 32'h3F00, 0, 0);
    step(32'h8000, 0, 0, 32'h3F00, 0, 0, "R4");
    step(32'hFFFF, 0, 0, 32'h3F00, 0, 0, "R4");
    // R5: pattern banks
    step(32'h7FFE, 1, 32'hF3, 32'h3F00, 0, 0);
    step(32'h7FFF, 1, 32'h25, 32'h0123, 0, 0, "R5");
    step(32'h0000, 0, 0, 32'h1ABC, 0, 0, "R5");
    step(32'h0000, 0, 0, 32'h0123, 0, 0, "R5");
    // R6: register bytes also land in work RAM
    step(32'h7FFD, 0, 0, 32'h3F00, 0, 0);
    step(32'h7FFE, 0, 0, 32'h3F00, 0, 0);
    step(32'h7FFF, 0, 0, 32'h3F00, 0, 0);
    // R7: bank wrap with 12 banks present
    step(32'h7FFE, 1, 32'h0D, 32'h3F00, 0, 0);
    step(32'h0000, 0, 0, 32'h0456, 0, 0, "R7");
    step(32'h7FFF, 1, 32'h0F, 32'h1FFF, 0, 0, "R5");
    step(32'h0000, 0, 0, 32'h1FFF, 0, 0, "R7");
    // R9: pattern write at banked address, then bank change
    step(32'h0000, 0, 0, 32'h0456, 1, 32'h77, "R9");
    step(32'h0000, 0, 0, 32'h0456, 0, 0, "R9");
    step(32'h7FFE, 1, 32'h02, 32'h0456, 0, 0, "R9");
    step(32'h0000, 0, 0, 32'h0456, 0, 0, "R9");
    // R8: horizontal mirroring and aliasing
    step(32'h0000, 0, 0, 32'h2005, 1, 32'h11);
    step(32'h0000, 0, 0, 32'h2805, 1, 32'h22);
    step(32'h0000, 0, 0, 32'h2405, 0, 0);
    step(32'h0000, 0, 0, 32'h2C05, 0, 0);
    step(32'h0000, 0, 0, 32'h3005, 0, 0);
    step(32'h0000, 0, 0, 32'h3EFF, 1, 32'h33);
    step(32'h0000, 0, 0, 32'h2EFF, 0, 0);
    step(32'h0000, 0, 0, 32'h3F00, 0, 0);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int ca, pa, r;
      r = int'($urandom % 5);
      case (r)
        0: ca = 32'h6000 + int'($urandom % 32'h2000);
        1: ca = 32'h8000 + int'($urandom % 32'h8000);
        2: ca = 32'h7FFD + int'($urandom % 3);
        3: ca = 32'h6000 + int'($urandom % 16);
        default: ca = int'($urandom % 32'h6000);
      endcase
      r = int'($urandom % 4);
      case (r)
        0: pa = int'($urandom % 32'h2000);
        1: pa = int'($urandom % 64) + ((int'($urandom % 2)) << 12);
        2: pa = 32'h2000 + int'($urandom % 32'h1F00);
        default: pa = 32'h3F00 + int'($urandom % 256);
      endcase
      step(ca, bit'($urandom % 2), int'($urandom % 256),
           pa, bit'($urandom % 2), int'($urandom % 256), "R7");
    end
    step(32'h0000, 0, 0, 32'h3F00, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule